// File: doc/BRIEF.md
# Serial Control Register File

This block receives configuration words over a write-only three-wire serial link: a shift clock, a data line and a latch strobe. Each 16-bit word carries a two-bit register selector in its lowest bits. The remaining bits are stored in one of four registers: two control registers and two 14-bit channel volume registers. Each stored field is presented as a decoded output to the rest of the audio path.

The shift clock has no fixed relationship to the system clock. It may run as a 16-pulse burst per word or run continuously. Serial bits are collected in the shift-clock domain. The rising edge of the latch strobe freezes the last 16 bits. That edge is then carried into the system clock domain through a three-stage synchronizer, and the frozen word is committed to the selected register there. An active-low reset restores every register to its default, asynchronously.

Top module: `spi_cfg_regs`

## Requirements
- R1: While reset is held, and after it is released with no word written, every control field reads zero, `mclk_fs` reads 256, and both volumes read 14'h3FFF.
- R2: `ser_din` is sampled on each rising edge of `ser_clk`, MSB first. On a rising edge of `ser_latch`, the last 16 bits sampled form the word, so bits shifted in earlier by a continuous clock have no effect.
- R3: Selector 00 (word bits 1:0) writes control 0. The fields are: bit 15 `pwr_down`, bit 14 `mute`, bits 13:12 `data_mode`, bits 11:10 `out_mode`, bits 9:8 `rate_sel`, bits 7:6 `deemph`, bits 5:4 `ser_fmt`, bits 3:2 `word_w`.
- R4: Selector 01 writes control 1. The fields are: bits 10:9 clock ratio code, bit 8 `zero_pol`, bit 7 `bit_rate`, bit 6 `phase_mode`, bits 5:4 `phase_sel`, bit 3 `bit_inv`, bit 2 `clk_edge`. Bits 15:11 are ignored.
- R5: Selector 10 writes word bits 15:2 into `vol_l`, and selector 11 writes them into `vol_r`.
- R6: A write changes only the register its selector names. Every other output keeps its value.
- R7: `out_mode` shows codes 00, 10 and 11 as written. Code 01 is shown as 00 (stereo).
- R8: `mclk_fs` decodes the clock ratio code as follows: 00 gives 256, 01 gives 512, 10 gives 768, 11 gives 384.
- R9: A committed word appears on the outputs at the third rising `clk` edge after the `ser_latch` rising edge, and not before. Outputs change only on a commit.
- R10: Pulling `rst_n` low at any time restores the defaults of R1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Word commit strobe, rising edge |
| pwr_down | output | 1 | Power-down request |
| mute | output | 1 | Mute request |
| data_mode | output | 2 | Input data mode |
| out_mode | output | 2 | Channel output mode |
| rate_sel | output | 2 | Sample rate select |
| deemph | output | 2 | De-emphasis curve |
| ser_fmt | output | 2 | Serial audio format |
| word_w | output | 2 | Audio word width code |
| mclk_fs | output | 10 | Master clock ratio as a multiple of fs |
| zero_pol | output | 1 | Zero flag polarity |
| bit_rate | output | 1 | Bitstream rate select |
| phase_mode | output | 1 | Phase modulation enable |
| phase_sel | output | 2 | Phase select |
| bit_inv | output | 1 | Bitstream inversion |
| clk_edge | output | 1 | Bitstream clock edge select |
| vol_l | output | 14 | Left volume |
| vol_r | output | 14 | Right volume |

## Verification
Four properties are checked on every cycle:
- The reserved output-mode code never appears at `out_mode`.
- `mclk_fs` always holds one of the four legal multiples.
- The stored registers hold still in any cycle without a commit.
- A commit aimed at another register leaves the left volume untouched.

Only the bench scenarios can show the rest:
- The bit positions of each field.
- That bits shifted in before the final 16 are discarded.
- The exact three-edge commit latency.
- The asynchronous effect of a mid-run reset.

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 14,
  parameter int SYNC_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             ser_latch,
  output logic             pwr_down,
  output logic             mute,
  output logic [1:0]       data_mode,
  output logic [1:0]       out_mode,
  output logic [1:0]       rate_sel,
  output logic [1:0]       deemph,
  output logic [1:0]       ser_fmt,
  output logic [1:0]       word_w,
  output logic [9:0]       mclk_fs,
  output logic             zero_pol,
  output logic             bit_rate,
  output logic             phase_mode,
  output logic [1:0]       phase_sel,
  output logic             bit_inv,
  output logic             clk_edge,
  output logic [VOL_W-1:0] vol_l,
  output logic [VOL_W-1:0] vol_r
);
  localparam int PAY_W = WORD_W - 2;
  localparam int C1_W  = 9;

  logic [WORD_W-1:0] shift_q, word_q;
  logic [SYNC_N-1:0] sync_q;
  logic [PAY_W-1:0]  c0_q;
  logic [C1_W-1:0]   c1_q;
  logic [VOL_W-1:0]  vl_q, vr_q;
  logic              commit;

  always_ff @(posedge ser_clk or negedge rst_n)
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[WORD_W-2:0], ser_din};

  always_ff @(posedge ser_latch or negedge rst_n)
    if (!rst_n) word_q <= '0;
    else        word_q <= shift_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], ser_latch};

  assign commit = sync_q[SYNC_N-2] & ~sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
      vl_q <= '1;
      vr_q <= '1;
    end else if (commit) begin
      case (word_q[1:0])
        2'b00:   c0_q <= word_q[WORD_W-1:2];
        2'b01:   c1_q <= word_q[C1_W+1:2];
        2'b10:   vl_q <= word_q[WORD_W-1 -: VOL_W];
        default: vr_q <= word_q[WORD_W-1 -: VOL_W];
      endcase
    end

  assign {pwr_down, mute, data_mode} = c0_q[13:10];
  assign out_mode = (c0_q[9:8] == 2'b01) ? 2'b00 : c0_q[9:8];
  assign {rate_sel, deemph, ser_fmt, word_w} = c0_q[7:0];

  always_comb
    case (c1_q[8:7])
      2'b00:   mclk_fs = 10'd256;
      2'b01:   mclk_fs = 10'd512;
      2'b10:   mclk_fs = 10'd768;
      default: mclk_fs = 10'd384;
    endcase

  assign {zero_pol, bit_rate, phase_mode, phase_sel, bit_inv, clk_edge} = c1_q[6:0];
  assign vol_l = vl_q;
  assign vol_r = vr_q;

  // R7
  out_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode != 2'b01);

  // R8
  mclk_fs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_fs == 10'd256) || (mclk_fs == 10'd384) ||
    (mclk_fs == 10'd512) || (mclk_fs == 10'd768));

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({c0_q, c1_q, vl_q, vr_q}));

  // R6
  vol_l_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word_q[1:0] != 2'b10) |=> $stable(vol_l));
endmodule

// File: tb/spi_cfg_regs_test.sv
`timescale 1ns/1ps
module spi_cfg_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_latch = 1'b0;
  logic pwr_down, mute, zero_pol, bit_rate, phase_mode, bit_inv, clk_edge;
  logic [1:0] data_mode, out_mode, rate_sel, deemph, ser_fmt, word_w, phase_sel;
  logic [9:0] mclk_fs;
  logic [13:0] vol_l, vol_r;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_cfg_regs uut (.*);

  function automatic logic [16:0] grp(input logic [1:0] a);
    case (a)
      2'd0: grp = {3'b0, pwr_down, mute, data_mode, out_mode, rate_sel, deemph, ser_fmt, word_w};
      2'd1: grp = {mclk_fs, zero_pol, bit_rate, phase_mode, phase_sel, bit_inv, clk_edge};
      2'd2: grp = {3'b0, vol_l};
      default: grp = {3'b0, vol_r};
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = bits[i];
      #10 ser_clk = 1'b1;
      #10 ser_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [15:0] w);
    shift({16'h0, w}, 16);
    #10 ser_latch = 1'b1;
    #40 ser_latch = 1'b0;
    #20;
  endtask

  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {16'hFFFC, 17'h03FFF},   // R3 all ones, mono-right passes (R7)
    {16'h5554, 17'h01455},   // R7 code 01 shown as stereo
    {16'hA5A4, 17'h02869},   // R3 mixed fields
    {16'h0800, 17'h00200},   // R7 mono-left passes
    {16'h0001, 17'h08000},   // R4/R8 ratio 256
    {16'h07FD, 17'h0C07F},   // R4/R8 ratio 384, all flags set
    {16'hFA01, 17'h10000},   // R4/R8 ratio 512, upper bits ignored
    {16'h0455, 17'h18015},   // R4/R8 ratio 768, alternating flags
    {16'h0002, 17'h00000},   // R5 left volume zero
    {16'h1237, 17'h0048D},   // R5 right volume
    {16'hABCE, 17'h02AF3}    // R5 left volume
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    check("R1 ctrl0 in reset", grp(0), 17'h0);
    check("R1 vol_l in reset", grp(2), 17'h3FFF);
    rst_n = 1'b1;
    #20;
    check("R1 ctrl0", grp(0), 17'h0);
    check("R1 ctrl1", grp(1), 17'h08000);
    check("R1 vol_l", grp(2), 17'h3FFF);
    check("R1 vol_r", grp(3), 17'h3FFF);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][32:17]);
      check($sformatf("R3/R4/R5 vector %0d", i), grp(VEC[i][18:17]), VEC[i][16:0]);
    end

    // R6: the last writes touched only the left volume
    check("R6 vol_r kept", grp(3), 17'h0048D);
    check("R6 ctrl0 kept", grp(0), 17'h00200);
    check("R6 ctrl1 kept", grp(1), 17'h18015);

    // R2: continuous clock, 4 leading bits dropped
    shift(32'h000F_0006, 20);
    #10 ser_latch = 1'b1;
    #40 ser_latch = 1'b0;
    #20;
    check("R2 extra bits dropped", grp(2), 17'h00001);

    // R9: exact commit latency
    shift(32'h0000_FFFF, 16);
    #12 ser_latch = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 not before third edge", grp(3), 17'h0048D);
    @(posedge clk); #1;
    check("R9 at third edge", grp(3), 17'h3FFF);
    #30 ser_latch = 1'b0;
    #20;

    // R10: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R10 ctrl0 default", grp(0), 17'h0);
    check("R10 ctrl1 default", grp(1), 17'h08000);
    check("R10 vol_l default", grp(2), 17'h3FFF);
    #20 rst_n = 1'b1;
    #20;
    send(16'h4000);
    check("R3 mute only", grp(0), 17'h01000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule